// File: doc/BRIEF.md
# Asynchronous Host Register Port

This block is a slave port that lets a host processor read and write a small set of control registers and a palette store over a 10-bit data bus. The host drives an active-low select, a read/write line and a two-bit command code. The block samples these strobes into its own clock domain through a synchronizer and acts on the edges it detects there. The command and direction are taken when the select falls, and write data is taken when it rises.

Values in the block are always 10 bits wide. The host can move them in one of three bus formats. In the wide format a single transfer carries the whole value. In the split format two transfers carry each value: the upper eight bits first, then the lower two. In the narrow format only eight bits are carried and the two lowest stored bits are zero. Palette accesses advance an internal index after each complete value, so a run of entries can be loaded or dumped without rewriting the index.

The block drives its bus output only while a read access is active. It releases the bus once the end of that access has been seen.

Top module: `host_reg_port`

## Requirements
- R1: In the cycle after reset is sampled high, the bus output enable is 0, the index is 0, and the format is wide. While the select has stayed high since reset, the data output reads 0 and every register-file entry reads 0.
- R2: The output enable goes high only for an access that began with the read/write line high (1 = read, 0 = write). It stays low for every write. It is low again within four clocks after the select returns high.
- R3: Direction and command are taken when the select falls. Changing the read/write line, the command or the data while the select is low has no effect on what the access does: a read does not turn into a write, and the driven read data does not change.
- R4: Write data is the value on the bus at the time the select rises. Values present earlier in the same access are discarded.
- R5: Command code 00 is the index register. A write loads the index from the bus bits [3:0] and also resets the split-format half tracking to the upper half. A read returns the index zero-extended to 10 bits.
- R6: Command code 11 is the format register. A write loads bus bits [1:0] into the format and also resets the half tracking. The codes are 00 wide, 01 split and 10 narrow; code 11 acts as wide. A read returns the format code zero-extended.
- R7: In wide format a data write stores bus[9:0], and a data read drives the full stored value.
- R8: In narrow format a data write stores {bus[7:0], 2'b00}, and a data read drives {2'b00, value[9:2]}.
- R9: In split format the first data write of a pair provides value[9:2] from bus[7:0]. The second provides value[1:0] from bus[1:0], and the value is stored when the second transfer completes.
- R10: In split format the first data read of a pair drives {2'b00, value[9:2]} and the second drives {8'b0, value[1:0]}. Reads and writes share one half flag, which flips after each data transfer.
- R11: Command code 10 accesses the palette entry at the index. After each complete value is read or written (every transfer in wide or narrow format, every second transfer in split format), the index advances by one and wraps from the last entry to 0.
- R12: Command code 01 accesses the register-file entry selected by the low bits of the index, and it never changes the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low access select, asynchronous to clk |
| rw | input | 1 | 1 = read, 0 = write; taken when cs_n falls |
| cmd | input | 2 | Access type: 00 index, 01 register file, 10 palette, 11 format |
| dbus_i | input | 10 | Data from the host bus |
| dbus_o | output | 10 | Read data toward the host bus |
| dbus_oe | output | 1 | High while the block drives the bus |

## Verification
The hardest state to reach from the ports is a split-format pair that is left half finished and then cut short, either by an index or format write or by a pair that mixes a read with a write or the register file with the palette. The random stimulus switches format and index between data accesses, so pairs are often interrupted in these ways. A bench model that tracks the half flag and the held upper byte predicts every read. Directed accesses also change the direction, command and data in the middle of an access, to show that only the falling and rising select edges matter.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int DW    = 10;
  localparam int LOW_W = 2;
  localparam int HI_W  = DW - LOW_W;

  typedef enum logic [1:0] {
    CMD_INDEX = 2'b00,
    CMD_REGF  = 2'b01,
    CMD_PAL   = 2'b10,
    CMD_FMT   = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    BW_WIDE   = 2'b00,
    BW_SPLIT  = 2'b01,
    BW_NARROW = 2'b10,
    BW_ALT    = 2'b11
  } bw_e;

  function automatic logic [DW-1:0] fmt_rd(bw_e bw, logic second, logic [DW-1:0] v);
    case (bw)
      BW_SPLIT:  return second ? {{HI_W{1'b0}}, v[LOW_W-1:0]} : {{LOW_W{1'b0}}, v[DW-1:LOW_W]};
      BW_NARROW: return {{LOW_W{1'b0}}, v[DW-1:LOW_W]};
      default:   return v;
    endcase
  endfunction
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hrp_xfer.sv
module hrp_xfer
  import hrp_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          rw_in,
  input  cmd_e          cmd_in,
  input  logic [DW-1:0] wdata,
  input  bw_e           mode,
  output logic          lat_rw,
  output cmd_e          lat_cmd,
  output logic          half,
  output logic          wr_reg,
  output logic          wr_pal,
  output logic [DW-1:0] wr_val,
  output logic          pal_done,
  output logic          idx_wr,
  output logic          fmt_wr
);
  logic [HI_W-1:0] hold_q;
  logic            is_data;
  logic            complete;

  always_comb begin
    is_data  = (lat_cmd == CMD_REGF) || (lat_cmd == CMD_PAL);
    complete = !((mode == BW_SPLIT) && !half);
    case (mode)
      BW_SPLIT:  wr_val = {hold_q, wdata[LOW_W-1:0]};
      BW_NARROW: wr_val = {wdata[HI_W-1:0], {LOW_W{1'b0}}};
      default:   wr_val = wdata;
    endcase
    wr_reg   = stop && !lat_rw && complete && (lat_cmd == CMD_REGF);
    wr_pal   = stop && !lat_rw && complete && (lat_cmd == CMD_PAL);
    pal_done = stop && complete && (lat_cmd == CMD_PAL);
    idx_wr   = stop && !lat_rw && (lat_cmd == CMD_INDEX);
    fmt_wr   = stop && !lat_rw && (lat_cmd == CMD_FMT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_rw  <= 1'b0;
      lat_cmd <= CMD_INDEX;
      half    <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (start) begin
        lat_rw  <= rw_in;
        lat_cmd <= cmd_in;
      end
      if (stop) begin
        if (is_data && (mode == BW_SPLIT)) begin
          half <= ~half;
          if (!half && !lat_rw) hold_q <= wdata[HI_W-1:0];
        end else if (!is_data && !lat_rw) begin
          half <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/hrp_store.sv
module hrp_store
  import hrp_pkg::*;
#(
  parameter int PAL_DEPTH = 16,
  parameter int NREG      = 8,
  parameter int ADDR_W    = 4,
  parameter int REG_AW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              wr_reg,
  input  logic              wr_pal,
  input  logic [DW-1:0]     wr_val,
  output logic [DW-1:0]     reg_q,
  output logic [DW-1:0]     pal_q
);
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] pal_mem [PAL_DEPTH];
  logic [REG_AW-1:0] ridx;

  assign ridx = ptr[REG_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      reg_q <= '0;
    end else begin
      if (wr_reg) regs[ridx] <= wr_val;
      reg_q <= regs[ridx];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_pal) pal_mem[ptr] <= wr_val;
    pal_q <= pal_mem[ptr];
  end
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import hrp_pkg::*;
#(
  parameter int PAL_DEPTH   = 16,
  parameter int NREG        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       rw,
  input  logic [1:0] cmd,
  input  logic [9:0] dbus_i,
  output logic [9:0] dbus_o,
  output logic       dbus_oe
);
  localparam int ADDR_W = $clog2(PAL_DEPTH);
  localparam int REG_AW = $clog2(NREG);
  localparam int BUN_W  = 1 + 1 + 2 + DW;
  localparam logic [BUN_W-1:0] SYNC_RST = {1'b1, {(BUN_W-1){1'b0}}};

  logic [BUN_W-1:0] sync_q;
  logic             cs_s, rw_s, cs_d;
  logic [1:0]       cmd_s;
  logic [DW-1:0]    d_s;
  logic             cs_fall, cs_rise;

  logic [ADDR_W-1:0] ptr_q;
  bw_e               mode_q;
  logic              x_lat_rw, x_half;
  cmd_e              x_lat_cmd;
  logic              wr_reg, wr_pal, pal_done, idx_wr, fmt_wr;
  logic [DW-1:0]     wr_val, reg_q, pal_q, rd_val;

  hrp_sync #(.W(BUN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, rw, cmd, dbus_i}), .q(sync_q)
  );

  assign {cs_s, rw_s, cmd_s, d_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) cs_d <= 1'b1;
    else     cs_d <= cs_s;
  end

  assign cs_fall = cs_d && !cs_s;
  assign cs_rise = !cs_d && cs_s;

  hrp_xfer u_xfer (
    .clk(clk), .rst(rst), .start(cs_fall), .stop(cs_rise),
    .rw_in(rw_s), .cmd_in(cmd_e'(cmd_s)), .wdata(d_s), .mode(mode_q),
    .lat_rw(x_lat_rw), .lat_cmd(x_lat_cmd), .half(x_half),
    .wr_reg(wr_reg), .wr_pal(wr_pal), .wr_val(wr_val),
    .pal_done(pal_done), .idx_wr(idx_wr), .fmt_wr(fmt_wr)
  );

  hrp_store #(.PAL_DEPTH(PAL_DEPTH), .NREG(NREG), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_store (
    .clk(clk), .rst(rst), .ptr(ptr_q), .wr_reg(wr_reg), .wr_pal(wr_pal),
    .wr_val(wr_val), .reg_q(reg_q), .pal_q(pal_q)
  );

  always_comb begin
    case (cmd_e'(cmd_s))
      CMD_INDEX: rd_val = DW'(ptr_q);
      CMD_FMT:   rd_val = DW'(mode_q);
      CMD_REGF:  rd_val = fmt_rd(mode_q, x_half, reg_q);
      default:   rd_val = fmt_rd(mode_q, x_half, pal_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      mode_q <= BW_WIDE;
    end else begin
      if (idx_wr)        ptr_q <= d_s[ADDR_W-1:0];
      else if (pal_done) ptr_q <= ptr_q + 1'b1;
      if (fmt_wr) mode_q <= bw_e'(d_s[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbus_oe <= 1'b0;
      dbus_o  <= '0;
    end else if (cs_fall && rw_s) begin
      dbus_oe <= 1'b1;
      dbus_o  <= rd_val;
    end else if (cs_rise) begin
      dbus_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/hrp_chk.sv
module hrp_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              dbus_oe,
  input logic              cs_d,
  input logic              half,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] ptr,
  input logic              pal_done,
  input logic              lat_rw,
  input logic              cs_fall,
  input logic [1:0]        lat_cmd
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!dbus_oe && mode == 2'b00 && ptr == '0));

  // R2
  oe_select_low_chk: assert property (@(posedge clk) disable iff (rst)
    dbus_oe |-> !cs_d);

  // R2
  oe_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dbus_oe) |-> lat_rw);

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_fall |=> $stable(lat_cmd) && $stable(lat_rw));

  // R9
  half_split_only_chk: assert property (@(posedge clk) disable iff (rst)
    half |-> mode == 2'b01);

  // R11
  pal_step_chk: assert property (@(posedge clk) disable iff (rst)
    pal_done |=> ptr == $past(ptr) + 1'b1);
endmodule

bind host_reg_port hrp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .dbus_oe(dbus_oe), .cs_d(cs_d), .half(x_half),
  .mode(mode_q), .ptr(ptr_q), .pal_done(pal_done), .lat_rw(x_lat_rw),
  .cs_fall(cs_fall), .lat_cmd(x_lat_cmd)
);

// File: tb/test_host_reg_port.sv
module test_host_reg_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       rw = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [9:0] dbus_i = '0;
  logic [9:0] dbus_o;
  logic       dbus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [9:0] m_regs [8];
  logic [9:0] m_pal  [16];
  logic [3:0] m_ptr;
  logic [1:0] m_mode;
  logic       m_half;
  logic [7:0] m_hold;

  host_reg_port i_host_reg_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .cmd(cmd),
    .dbus_i(dbus_i), .dbus_o(dbus_o), .dbus_oe(dbus_oe)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] fmt(input logic [9:0] v);
    if (m_mode == 2'b01) return m_half ? {8'b0, v[1:0]} : {2'b0, v[9:2]};
    if (m_mode == 2'b10) return {2'b0, v[9:2]};
    return v;
  endfunction

  task automatic mdl(input logic r, input logic [1:0] c, input logic [9:0] d, output logic [9:0] exp);
    logic [9:0] v, nv;
    logic complete;
    v = (c == 2'b01) ? m_regs[m_ptr[2:0]] : m_pal[m_ptr];
    exp = '0;
    if (r) begin
      if (c == 2'b00) exp = {6'b0, m_ptr};
      else if (c == 2'b11) exp = {8'b0, m_mode};
      else exp = fmt(v);
    end
    if (c == 2'b00 && !r) begin m_ptr = d[3:0]; m_half = 0; end
    if (c == 2'b11 && !r) begin m_mode = d[1:0]; m_half = 0; end
    if (c == 2'b01 || c == 2'b10) begin
      complete = 1; nv = d;
      if (m_mode == 2'b01) begin
        if (!m_half) begin
          m_half = 1; complete = 0;
          if (!r) m_hold = d[7:0];
        end else begin
          m_half = 0; nv = {m_hold, d[1:0]};
        end
      end else if (m_mode == 2'b10) nv = {d[7:0], 2'b00};
      if (complete && !r) begin
        if (c == 2'b01) m_regs[m_ptr[2:0]] = nv;
        else m_pal[m_ptr] = nv;
      end
      if (complete && c == 2'b10) m_ptr = m_ptr + 1;
    end
  endtask

  task automatic acc(input string tag, input logic r, input logic [1:0] c, input logic [9:0] d,
                     input bit mid = 0, input logic r2 = 0, input logic [1:0] c2 = 0,
                     input logic [9:0] d2 = 0);
    logic [9:0] exp;
    @(negedge clk);
    rw = r; cmd = c; dbus_i = d; cs_n = 1'b0;
    repeat (4) @(negedge clk);
    if (mid) begin
      rw = r2; cmd = c2; dbus_i = d2;
      repeat (3) @(negedge clk);
    end
    mdl(r, c, mid ? d2 : d, exp);
    if (r) begin
      chk({tag, " oe R2"}, {9'b0, dbus_oe}, 10'd1);
      chk(tag, dbus_o, exp);
    end else begin
      chk("R2 write oe", {9'b0, dbus_oe}, 10'd0);
    end
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 release", {9'b0, dbus_oe}, 10'd0);
  endtask

  function automatic string tag_of(input logic [1:0] c);
    if (c == 2'b00) return "R5";
    if (c == 2'b11) return "R6";
    if (m_mode == 2'b01) return "R9_R10";
    if (m_mode == 2'b10) return "R8";
    if (c == 2'b10) return "R11";
    return "R7_R12";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2a17));
    for (int i = 0; i < 8; i++) m_regs[i] = '0;
    for (int i = 0; i < 16; i++) m_pal[i] = '0;
    m_ptr = 0; m_mode = 0; m_half = 0; m_hold = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe", {9'b0, dbus_oe}, 10'd0);
    chk("R1 data", dbus_o, 10'd0);
    acc("R1 fmt", 1, 2'b11, 10'h3FF);
    acc("R1 index", 1, 2'b00, 10'h3FF);
    acc("R1 regf", 1, 2'b01, 10'h000);
    // R7 R12 wide register file
    acc("R5", 0, 2'b00, 10'h003);
    acc("R7", 0, 2'b01, 10'h2A5);
    acc("R7", 1, 2'b01, 10'h000);
    acc("R12 index", 1, 2'b00, 10'h000);
    // R11 palette load and wrap
    acc("R5", 0, 2'b00, 10'h000);
    for (int i = 0; i < 16; i++) acc("R11 load", 0, 2'b10, 10'((i * 37 + 5) & 10'h3FF));
    acc("R11 wrap", 1, 2'b00, 10'h000);
    for (int i = 0; i < 16; i++) acc("R11 dump", 1, 2'b10, 10'h000);
    // R8 narrow
    acc("R6", 0, 2'b11, 10'h002);
    acc("R5", 0, 2'b00, 10'h005);
    acc("R8", 0, 2'b01, 10'h3C7);
    acc("R8", 1, 2'b01, 10'h000);
    acc("R6", 0, 2'b11, 10'h000);
    acc("R8 wide view", 1, 2'b01, 10'h000);
    // R9 R10 split
    acc("R6", 0, 2'b11, 10'h001);
    acc("R5", 0, 2'b00, 10'h002);
    acc("R9 hi", 0, 2'b10, 10'h0AB);
    acc("R9 lo", 0, 2'b10, 10'h002);
    acc("R11 split step", 1, 2'b00, 10'h000);
    acc("R5", 0, 2'b00, 10'h002);
    acc("R10 hi", 1, 2'b10, 10'h000);
    acc("R10 lo", 1, 2'b10, 10'h000);
    // R5 toggle cleared by index write
    acc("R9 hi", 0, 2'b01, 10'h0FF);
    acc("R5", 0, 2'b00, 10'h002);
    acc("R5 half reset", 1, 2'b10, 10'h000);
    acc("R6 half reset", 0, 2'b11, 10'h001);
    acc("R6 half reset", 1, 2'b10, 10'h000);
    // R6 code 11 acts wide
    acc("R6", 0, 2'b11, 10'h003);
    acc("R6 alt", 0, 2'b01, 10'h155);
    acc("R6 alt", 1, 2'b01, 10'h000);
    // R3 read stays read when lines change mid-access
    acc("R3", 1, 2'b01, 10'h000, 1, 0, 2'b10, 10'h3AA);
    acc("R3", 1, 2'b01, 10'h000);
    // R4 write takes data present at the rising select
    acc("R4", 0, 2'b01, 10'h111, 1, 0, 2'b01, 10'h2DE);
    acc("R4", 1, 2'b01, 10'h000);
    // random mix
    for (int n = 0; n < 500; n++) begin
      int p;
      logic [1:0] c;
      logic r;
      logic [9:0] d;
      p = $urandom_range(0, 99);
      d = 10'($urandom);
      r = 1'($urandom);
      if (p < 8) begin c = 2'b11; r = (p < 2); end
      else if (p < 18) c = 2'b00;
      else c = (p < 58) ? 2'b01 : 2'b10;
      acc(tag_of(c), r, c, d);
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule